// File: doc/BRIEF.md
# CAN Error Status and Interrupt Unit

This unit tracks the health of one CAN node. The protocol engine gives it a pulse for each transmit error, receive error and successful transfer. The unit turns these pulses into transmit and receive error counters. From those counters a three-state machine derives the fault-confinement state. The unit also latches which kinds of bus error were seen, raises interrupt flags when the node crosses a warning level, turns error passive or goes bus-off, and counts recessive-bit sequences so that it can recover from bus-off.

Software reaches the unit through a three-word register port:

- The control word holds the interrupt mask bits and a bit that disables recovery.
- The counter word shows both error counters.
- The status word combines two kinds of bit. The error-kind bits clear when the status word is read. The interrupt bits clear when software writes a one to them.

The state machine `cfs_err_counters` has three states:

- FC_ACTIVE goes to FC_PASSIVE when either counter rises above 127.
- FC_ACTIVE or FC_PASSIVE goes to FC_BUSOFF when a transmit error would push the transmit counter past 255.
- FC_PASSIVE returns to FC_ACTIVE when both counters are at 127 or below.
- FC_BUSOFF returns to FC_ACTIVE, with both counters cleared, when the recovery count completes.

Top module: `can_fault_status`

## Requirements
- R1: The counter word (reg_sel 1) reads the transmit counter in bits 7:0 and the receive counter in bits 15:8, with zeros above. Writes to it have no effect.
- R2: A transmit error adds 8 and a receive error adds 1. A successful transmit or receive subtracts 1 from its own counter, but never below 0. An error in the same cycle as a success on the same counter takes precedence, so the success is ignored. The receive counter saturates at 255.
- R3: Status bit 9 (transmit warning) and bit 8 (receive warning) are 1 while the matching counter is 96 or more. Status bit 17 (transmit) or bit 16 (receive) is set in the cycle the matching counter first reaches 96.
- R4: Status bits 5:4 carry the fault code: 0 means active, 1 means passive (either counter above 127), and 2 means bus-off. Entering passive sets status bit 1.
- R5: When a transmit error would push the transmit counter past 255, the node goes bus-off. The transmit counter then reads 255, status bit 2 is set, and every error and success event is ignored.
- R6: In bus-off, 128 recessive-sequence pulses return the node to active with both counters at 0. While control bit 6 is 1, those pulses are not counted.
- R7: Error kinds map to status bits 15..10 as follows:
  - bit 15: bit-one error (ev_kind[5])
  - bit 14: bit-zero error (ev_kind[4])
  - bit 13: acknowledge error (ev_kind[3])
  - bit 12: CRC error (ev_kind[2])
  - bit 11: form error (ev_kind[1])
  - bit 10: stuff error (ev_kind[0])

  Any error kind also sets status bit 1. A read of the status word (reg_sel 2) clears these bits, but a kind reported in the same cycle as the read stays set.
- R8: Writing a one to status bit 17, 16, 2, 1 or 0 clears that bit. Writes to all other status bits have no effect. A wake pulse sets bit 0.
- R9: The control word (reg_sel 0) keeps only bits 15, 14, 11, 10 and 6. irq is 1 when any of these holds:
  - status bit 2 and control bit 15
  - status bit 1 and control bit 14
  - status bit 17 and control bits 11 and 14
  - status bit 16 and control bits 10 and 14

  The wake flag never drives irq.
- R10: Status bit 7 follows bus_idle and status bit 6 follows bus_active in the same cycle.
- R11: After reset all three words read 0 and irq is 0. reg_sel 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_tx_err | input | 1 | Transmit error detected |
| ev_rx_err | input | 1 | Receive error detected |
| ev_tx_ok | input | 1 | Frame transmitted successfully |
| ev_rx_ok | input | 1 | Frame received successfully |
| ev_kind | input | 6 | Error kind pulses, bit 5 = bit-one error down to bit 0 = stuff error |
| ev_wake | input | 1 | Wake-up seen |
| ev_recessive11 | input | 1 | One sequence of 11 recessive bits seen |
| bus_idle | input | 1 | Bus is idle |
| bus_active | input | 1 | Node is transmitting or receiving |
| reg_sel | input | 2 | Word select: 0 control, 1 counters, 2 status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears error kinds when reading status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
Several internal faults are visible at the ports:

- A wrong step size or a missing floor in a counter shows up in the counter word on the clock edge after the event pulse.
- A state machine stuck in the wrong state shows up in the fault code on that same edge.
- A recovery counter that is off by one leaves the node in bus-off one pulse too long, or releases it one pulse early. The bench checks the pulse just before the boundary and the boundary pulse itself.
- Faults in the two clearing behaviours and in the mask gating show up at reg_rdata and irq in the cycle after the access.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    // status word bit positions
    localparam int ST_TWRN_INT = 17;
    localparam int ST_RWRN_INT = 16;
    localparam int ST_KIND_LO  = 10;
    localparam int ST_TX_WARN  = 9;
    localparam int ST_RX_WARN  = 8;
    localparam int ST_IDLE     = 7;
    localparam int ST_ACTIVE   = 6;
    localparam int ST_FC_LO    = 4;
    localparam int ST_BOFF_INT = 2;
    localparam int ST_ERR_INT  = 1;
    localparam int ST_WAKE_INT = 0;

    // control word bit positions
    localparam int CT_M_BOFF  = 15;
    localparam int CT_M_ERR   = 14;
    localparam int CT_M_TWRN  = 11;
    localparam int CT_M_RWRN  = 10;
    localparam int CT_NO_RECV = 6;

    localparam logic [31:0] CTL_WMASK = (32'd1 << CT_M_BOFF) | (32'd1 << CT_M_ERR) |
                                        (32'd1 << CT_M_TWRN) | (32'd1 << CT_M_RWRN) |
                                        (32'd1 << CT_NO_RECV);

endpackage

// File: rtl/cfs_busoff_recovery.sv
module cfs_busoff_recovery #(
    parameter int RECOV_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_busoff,
    input  logic rec11,
    input  logic recov_dis,
    output logic recov_done
);
    localparam int RC_W = $clog2(RECOV_COUNT + 1);

    logic [RC_W-1:0] cnt_q;

    assign recov_done = in_busoff && !recov_dis && rec11 &&
                        (cnt_q == RC_W'(RECOV_COUNT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!in_busoff || recov_done) begin
            cnt_q <= '0;
        end else if (rec11 && !recov_dis) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_RECOV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_busoff && recov_dis) |=> $stable(cnt_q)); // R6
    AST_RECOV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < RC_W'(RECOV_COUNT)); // R6

endmodule

// File: rtl/cfs_err_counters.sv
module cfs_err_counters import cfs_pkg::*; #(
    parameter int CNT_W       = 8,
    parameter int TX_ERR_STEP = 8,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err,
    input  logic             rx_err,
    input  logic             tx_ok,
    input  logic             rx_ok,
    input  logic             recov_done,
    output logic [CNT_W-1:0] tx_cnt,
    output logic [CNT_W-1:0] rx_cnt,
    output fc_state_e        state,
    output logic             tx_warn,
    output logic             rx_warn,
    output logic             tx_warn_rise,
    output logic             rx_warn_rise,
    output logic             enter_passive,
    output logic             enter_busoff
);
    localparam int               SUM_W   = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] WARN_C  = CNT_W'(WARN_LVL);
    localparam logic [CNT_W-1:0] PASS_C  = CNT_W'(PASSIVE_LVL);

    fc_state_e        state_q, state_n;
    logic [CNT_W-1:0] tx_q, rx_q, tx_nx, rx_nx;
    logic [SUM_W-1:0] tx_sum;
    logic             tx_ovf;

    // next counter values outside bus-off
    always_comb begin
        tx_sum = {1'b0, tx_q} + SUM_W'(TX_ERR_STEP);
        tx_ovf = tx_err && tx_sum[CNT_W];
        if (tx_err) begin
            tx_nx = tx_ovf ? CNT_MAX : tx_sum[CNT_W-1:0];
        end else if (tx_ok && tx_q != '0) begin
            tx_nx = tx_q - 1'b1;
        end else begin
            tx_nx = tx_q;
        end
        if (rx_err) begin
            rx_nx = (rx_q == CNT_MAX) ? CNT_MAX : rx_q + 1'b1;
        end else if (rx_ok && rx_q != '0) begin
            rx_nx = rx_q - 1'b1;
        end else begin
            rx_nx = rx_q;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FC_ACTIVE: begin
                if (tx_ovf)                                  state_n = FC_BUSOFF;
                else if (tx_nx >= PASS_C || rx_nx >= PASS_C) state_n = FC_PASSIVE;
            end
            FC_PASSIVE: begin
                if (tx_ovf)                                  state_n = FC_BUSOFF;
                else if (tx_nx < PASS_C && rx_nx < PASS_C)   state_n = FC_ACTIVE;
            end
            FC_BUSOFF: begin
                if (recov_done)                              state_n = FC_ACTIVE;
            end
            default:                                         state_n = FC_ACTIVE;
        endcase
    end

    // state and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_ACTIVE;
            tx_q    <= '0;
            rx_q    <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == FC_BUSOFF) begin
                if (recov_done) begin
                    tx_q <= '0;
                    rx_q <= '0;
                end
            end else begin
                tx_q <= tx_nx;
                rx_q <= rx_nx;
            end
        end
    end

    // outputs
    always_comb begin
        tx_cnt        = tx_q;
        rx_cnt        = rx_q;
        state         = state_q;
        tx_warn       = tx_q >= WARN_C;
        rx_warn       = rx_q >= WARN_C;
        tx_warn_rise  = (state_q != FC_BUSOFF) && (tx_q < WARN_C) && (tx_nx >= WARN_C);
        rx_warn_rise  = (state_q != FC_BUSOFF) && (rx_q < WARN_C) && (rx_nx >= WARN_C);
        enter_passive = (state_q == FC_ACTIVE) && (state_n == FC_PASSIVE);
        enter_busoff  = (state_q != FC_BUSOFF) && (state_n == FC_BUSOFF);
    end

    AST_ACTIVE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FC_ACTIVE) |-> (tx_q < PASS_C && rx_q < PASS_C)); // R4
    AST_BUSOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FC_BUSOFF && !recov_done) |=> ($stable(tx_q) && $stable(rx_q))); // R5
    AST_RECOV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FC_BUSOFF && recov_done) |=> (tx_q == '0 && rx_q == '0 && state_q == FC_ACTIVE)); // R6
    AST_RX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FC_BUSOFF && rx_q == CNT_MAX && rx_err) |=> (rx_q == CNT_MAX)); // R2
    AST_BUSOFF_TX_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FC_BUSOFF) |-> (tx_q == CNT_MAX || recov_done || $past(recov_done))); // R5

endmodule

// File: rtl/cfs_status_regs.sv
module cfs_status_regs import cfs_pkg::*; #(
    parameter int CNT_W  = 8,
    parameter int KIND_N = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KIND_N-1:0] kinds,
    input  logic              wake,
    input  logic              bus_idle,
    input  logic              bus_active,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  fc_state_e         state,
    input  logic              tx_warn,
    input  logic              rx_warn,
    input  logic              tx_warn_rise,
    input  logic              rx_warn_rise,
    input  logic              enter_passive,
    input  logic              enter_busoff,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              recov_dis,
    output logic              irq
);
    logic [31:0]       ctl_q;
    logic [KIND_N-1:0] kind_q;
    logic              twrn_q, rwrn_q, boff_q, err_q, wake_q;
    logic              rd_stat, wr_stat, wr_ctl;
    logic [31:0]       clr;
    logic [31:0]       stat_w;

    assign rd_stat = reg_rd && (reg_sel == SEL_STAT);
    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
    assign wr_ctl  = reg_wr && (reg_sel == SEL_CTRL);
    assign clr     = wr_stat ? reg_wdata : 32'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            kind_q <= '0;
            twrn_q <= 1'b0;
            rwrn_q <= 1'b0;
            boff_q <= 1'b0;
            err_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            if (wr_ctl) ctl_q <= reg_wdata & CTL_WMASK;
            kind_q <= rd_stat ? kinds : (kind_q | kinds);
            twrn_q <= tx_warn_rise | (twrn_q & ~clr[ST_TWRN_INT]);
            rwrn_q <= rx_warn_rise | (rwrn_q & ~clr[ST_RWRN_INT]);
            boff_q <= enter_busoff | (boff_q & ~clr[ST_BOFF_INT]);
            err_q  <= (|kinds) | enter_passive | (err_q & ~clr[ST_ERR_INT]);
            wake_q <= wake | (wake_q & ~clr[ST_WAKE_INT]);
        end
    end

    always_comb begin
        stat_w = '0;
        stat_w[ST_TWRN_INT]                    = twrn_q;
        stat_w[ST_RWRN_INT]                    = rwrn_q;
        stat_w[ST_KIND_LO +: KIND_N]           = kind_q;
        stat_w[ST_TX_WARN]                     = tx_warn;
        stat_w[ST_RX_WARN]                     = rx_warn;
        stat_w[ST_IDLE]                        = bus_idle;
        stat_w[ST_ACTIVE]                      = bus_active;
        stat_w[ST_FC_LO +: 2]                  = state;
        stat_w[ST_BOFF_INT]                    = boff_q;
        stat_w[ST_ERR_INT]                     = err_q;
        stat_w[ST_WAKE_INT]                    = wake_q;
        case (reg_sel)
            SEL_CTRL: reg_rdata = ctl_q;
            SEL_CNT:  reg_rdata = {{(32 - 2*CNT_W){1'b0}}, rx_cnt, tx_cnt};
            SEL_STAT: reg_rdata = stat_w;
            default:  reg_rdata = '0;
        endcase
    end

    assign recov_dis = ctl_q[CT_NO_RECV];
    assign irq = (boff_q & ctl_q[CT_M_BOFF]) |
                 (err_q  & ctl_q[CT_M_ERR]) |
                 (twrn_q & ctl_q[CT_M_TWRN] & ctl_q[CT_M_ERR]) |
                 (rwrn_q & ctl_q[CT_M_RWRN] & ctl_q[CT_M_ERR]);

    AST_KIND_RDCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && kinds == '0) |=> (kind_q == '0)); // R7
    AST_KIND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stat) |=> ((kind_q & $past(kind_q)) == $past(kind_q))); // R7
    AST_W1C_BOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[ST_BOFF_INT] && !enter_busoff) |=> !boff_q); // R8
    AST_BOFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        enter_busoff |=> boff_q); // R5
    AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~CTL_WMASK) == '0); // R9

endmodule

// File: rtl/can_fault_status.sv
module can_fault_status import cfs_pkg::*; #(
    parameter int CNT_W       = 8,
    parameter int TX_ERR_STEP = 8,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 128,
    parameter int RECOV_COUNT = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_tx_err,
    input  logic        ev_rx_err,
    input  logic        ev_tx_ok,
    input  logic        ev_rx_ok,
    input  logic [5:0]  ev_kind,
    input  logic        ev_wake,
    input  logic        ev_recessive11,
    input  logic        bus_idle,
    input  logic        bus_active,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    fc_state_e        state;
    logic tx_warn, rx_warn, tx_warn_rise, rx_warn_rise;
    logic enter_passive, enter_busoff, recov_done, recov_dis;

    cfs_err_counters #(
        .CNT_W(CNT_W), .TX_ERR_STEP(TX_ERR_STEP),
        .WARN_LVL(WARN_LVL), .PASSIVE_LVL(PASSIVE_LVL)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .tx_err(ev_tx_err), .rx_err(ev_rx_err), .tx_ok(ev_tx_ok), .rx_ok(ev_rx_ok),
        .recov_done(recov_done),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .state(state),
        .tx_warn(tx_warn), .rx_warn(rx_warn),
        .tx_warn_rise(tx_warn_rise), .rx_warn_rise(rx_warn_rise),
        .enter_passive(enter_passive), .enter_busoff(enter_busoff)
    );

    cfs_busoff_recovery #(.RECOV_COUNT(RECOV_COUNT)) u_recov (
        .clk(clk), .rst_n(rst_n),
        .in_busoff(state == FC_BUSOFF), .rec11(ev_recessive11),
        .recov_dis(recov_dis), .recov_done(recov_done)
    );

    cfs_status_regs #(.CNT_W(CNT_W), .KIND_N(6)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .kinds(ev_kind), .wake(ev_wake), .bus_idle(bus_idle), .bus_active(bus_active),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .state(state),
        .tx_warn(tx_warn), .rx_warn(rx_warn),
        .tx_warn_rise(tx_warn_rise), .rx_warn_rise(rx_warn_rise),
        .enter_passive(enter_passive), .enter_busoff(enter_busoff),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .recov_dis(recov_dis), .irq(irq)
    );

    AST_IRQ_QUIET_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq); // R11

endmodule

// File: tb/test_can_fault_status.sv
`timescale 1ns/1ps
module test_can_fault_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_tx_err = 0, ev_rx_err = 0, ev_tx_ok = 0, ev_rx_ok = 0;
    logic [5:0]  ev_kind = '0;
    logic        ev_wake = 0, ev_recessive11 = 0, bus_idle = 0, bus_active = 0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    can_fault_status i_can_fault_status (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_err(ev_tx_err), .ev_rx_err(ev_rx_err), .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok),
        .ev_kind(ev_kind), .ev_wake(ev_wake), .ev_recessive11(ev_recessive11),
        .bus_idle(bus_idle), .bus_active(bus_active),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // {tx_err, rx_err, tx_ok, rx_ok, expected tx, expected rx}
    localparam logic [19:0] VEC [0:10] = '{
        20'h40001, 20'h40002, 20'h10001, 20'h80801, 20'h20701, 20'hA0F01,
        20'h50F02, 20'h10F01, 20'h10F00, 20'h10F00, 20'h20E00
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic te, input logic re, input logic to, input logic ro,
                         input logic [5:0] kd, input logic wk, input logic rc, input int n);
        @(negedge clk);
        ev_tx_err = te; ev_rx_err = re; ev_tx_ok = to; ev_rx_ok = ro;
        ev_kind = kd; ev_wake = wk; ev_recessive11 = rc;
        repeat (n) @(negedge clk);
        ev_tx_err = 0; ev_rx_err = 0; ev_tx_ok = 0; ev_rx_ok = 0;
        ev_kind = '0; ev_wake = 0; ev_recessive11 = 0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(2'd0, d); check("R11 ctrl reset", d, 32'h0);
        rd(2'd1, d); check("R11 counters reset", d, 32'h0);
        rd(2'd2, d); check("R11 status reset", d, 32'h0);
        rd(2'd3, d); check("R11 unused select", d, 32'h0);
        check("R11 irq reset", {31'd0, irq}, 32'h0);

        // R2 counter rules, table walk
        foreach (VEC[i]) begin
            drive(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], 6'd0, 0, 0, 1);
            rd(2'd1, d);
            check($sformatf("R2 vector %0d", i), d, {16'd0, VEC[i][7:0], VEC[i][15:8]});
        end

        // R3 warning: 14 + 11*8 = 102
        drive(1, 0, 0, 0, 6'd0, 0, 0, 11);
        rd(2'd2, d); check("R3 tx warning flags", d, 32'h0002_0200);
        check("R9 irq masked off", {31'd0, irq}, 32'h0);
        wr(2'd0, 32'h0000_0800);
        @(negedge clk); check("R9 warn needs error mask", {31'd0, irq}, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R9 ctrl writable bits", d, 32'h0000_CC40);
        wr(2'd0, 32'h0000_4800);
        @(negedge clk); check("R9 warn irq enabled", {31'd0, irq}, 32'h1);
        wr(2'd2, 32'h0002_0000);
        rd(2'd2, d); check("R8 w1c warn int", d, 32'h0000_0200);
        check("R8 irq after clear", {31'd0, irq}, 32'h0);

        // R4 passive: 102 + 32 = 134
        drive(1, 0, 0, 0, 6'd0, 0, 0, 4);
        rd(2'd2, d); check("R4 passive code", d, 32'h0000_0212);
        check("R4 irq on passive", {31'd0, irq}, 32'h1);
        rd(2'd1, d); check("R4 counter 134", d, 32'h0000_0086);
        wr(2'd2, 32'h2);

        // R7 error kinds
        drive(0, 0, 0, 0, 6'b100001, 0, 0, 1);
        rd(2'd2, d); check("R7 kinds latched", d, 32'h0000_8612);
        rd(2'd2, d); check("R7 kinds cleared by read", d, 32'h0000_0212);
        wr(2'd2, 32'h2);
        @(negedge clk);
        ev_kind = 6'b000100; reg_sel = 2'd2; reg_rd = 1'b1;
        #1 d = reg_rdata;
        check("R7 read before same-cycle kind", d, 32'h0000_0210);
        @(negedge clk);
        ev_kind = '0; reg_rd = 1'b0;
        rd(2'd2, d); check("R7 same-cycle kind kept", d, 32'h0000_1212);
        wr(2'd2, 32'h2);
        wr(2'd2, 32'h0000_FFF8);
        rd(2'd2, d); check("R8 other bits unaffected", d, 32'h0000_0210);

        // R5 bus-off: 134 + 15*8 = 254, then one more
        drive(1, 0, 0, 0, 6'd0, 0, 0, 15);
        rd(2'd1, d); check("R5 counter before bus-off", d, 32'h0000_00FE);
        drive(1, 0, 0, 0, 6'd0, 0, 0, 1);
        rd(2'd2, d); check("R5 bus-off status", d, 32'h0000_0224);
        rd(2'd1, d); check("R5 tx counter at max", d, 32'h0000_00FF);
        check("R9 boff irq masked", {31'd0, irq}, 32'h0);
        wr(2'd0, 32'h0000_C800);
        @(negedge clk); check("R9 boff irq enabled", {31'd0, irq}, 32'h1);
        drive(1, 1, 0, 0, 6'd0, 0, 0, 3);
        drive(0, 0, 1, 1, 6'd0, 0, 0, 3);
        rd(2'd1, d); check("R5 events ignored in bus-off", d, 32'h0000_00FF);

        // R6 recovery
        wr(2'd0, 32'h0000_C840);
        drive(0, 0, 0, 0, 6'd0, 0, 1, 130);
        rd(2'd2, d); check("R6 recovery disabled", d[5:4], 32'h2);
        wr(2'd0, 32'h0000_C800);
        drive(0, 0, 0, 0, 6'd0, 0, 1, 127);
        rd(2'd2, d); check("R6 still bus-off at 127", d[5:4], 32'h2);
        drive(0, 0, 0, 0, 6'd0, 0, 1, 1);
        rd(2'd2, d); check("R6 active after 128", d, 32'h0000_0004);
        rd(2'd1, d); check("R6 counters cleared", d, 32'h0);
        wr(2'd2, 32'h4);
        @(negedge clk); check("R8 boff cleared irq", {31'd0, irq}, 32'h0);

        // R8 wake
        drive(0, 0, 0, 0, 6'd0, 1, 0, 1);
        rd(2'd2, d); check("R8 wake set", d, 32'h1);
        check("R9 wake no irq", {31'd0, irq}, 32'h0);
        wr(2'd2, 32'h1);
        rd(2'd2, d); check("R8 wake cleared", d, 32'h0);

        // R10 bus activity
        @(negedge clk); bus_idle = 1; bus_active = 0;
        #1 reg_sel = 2'd2; #1 check("R10 idle bit", reg_rdata, 32'h80);
        @(negedge clk); bus_idle = 0; bus_active = 1;
        #1 check("R10 active bit", reg_rdata, 32'h40);
        @(negedge clk); bus_active = 0;

        // R1 counter word read-only
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R1 counter write ignored", d, 32'h0);

        // R2 rx saturation, R3 rx warning, R4 passive via rx
        drive(0, 1, 0, 0, 6'd0, 0, 0, 300);
        rd(2'd1, d); check("R2 rx saturates", d, 32'h0000_FF00);
        rd(2'd2, d); check("R3 rx warning and passive", d, 32'h0001_0112);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule